// File: doc/BRIEF.md
# ADC start-of-conversion sequencer

This block sits in front of one shared analog-to-digital converter and serves sixteen independent conversion slots. Each slot holds a packed control word that picks the event that arms it, the analog channel it converts, and the length of its sample window. An armed slot waits with a pending flag set. A round-robin arbiter then selects pending slots one at a time. For the selected slot the block runs the sample window, starts the converter on the slot's channel and stores the result in the result register that carries the slot's number.

Slots can also be armed by a software force mask, or by one of two interrupt lines that the block raises itself when chosen slots finish. This lets one conversion chain into the next without outside help. If a slot is armed again while it is still waiting, a sticky overflow flag records the lost event. Giving several slots the same settings and the same trigger oversamples one channel into neighbouring result registers.

The controller has three states. IDLE: when the arbiter grants a slot (transition "grant"), the slot's window and channel are latched, its pending flag is cleared and the state moves to SAMPLE. SAMPLE: the window counter steps up once per cycle ("count"). When it reaches the latched window end ("window end"), the converter is started and the state moves to CONVERT. CONVERT: when the converter reports done ("done"), the result is written, the interrupt lines are updated and the state returns to IDLE. A fixed-latency converter stub stands in for the analog converter.

Top module: `soc_sequencer`

## Requirements
- R1: A control word written to slot `cfg_idx` is decoded with bits [5:0] as the window field, [9:6] as the channel and [15:11] as the trigger code. Bit 10 is ignored. Each result equals {channel[3:0], k[7:0]}, where k is the number of conversions completed since reset, modulo 256. It is written to the result register of the slot that produced it, and that register can be read back through `rd_idx`/`rd_data`. Every result register reads 0 after reset.
- R2: Trigger code 0 is software only. Codes 1 to 4 select `tmr_trig` bits 0 to 3. Codes 5 to 12 select `ext_trig` bits 0 to 7. Codes 13 to 31 select nothing. A rising edge on the selected line sets the slot's pending flag at that clock edge. A line held high gives only one event.
- R3: If an arming event reaches a slot whose pending flag is set, and that slot is not being granted in the same cycle, the slot's overflow flag is set and the event is dropped.
- R4: Overflow flags are sticky. Writing `ovf_clr_we` with `ovf_clr_mask` clears the flags whose mask bits are 1. A new overflow in the same cycle wins over the clear.
- R5: A cycle with `force_we` high arms every slot whose `force_mask` bit is 1, exactly like a trigger, including the overflow rule of R3.
- R6: At most one conversion is in progress at any time. A slot's pending flag clears at the edge where its conversion is granted, and a grant happens only while a flag is pending.
- R7: The sample window lasts max(window field, 6) + 1 cycles and the converter takes `CONV_LAT` (default 4) cycles. `busy` is therefore high for exactly window + `CONV_LAT` cycles per conversion. The `res_we` pulse comes in the cycle right after `busy` falls.
- R8: Pending slots are served round-robin. The search starts at the slot after the one most recently converted, and slot 0 is searched first after reset.
- R9: `int1` (`int2`) pulses for one cycle, together with `res_we`, when the finishing slot equals `int1_slot` (`int2_slot`).
- R10: A per-slot 2-bit re-arm field, written with `rtg_we` for slot `cfg_idx`, selects 0 = none, 1 = `int1`, 2 = `int2` or 3 = none. A pulse on the selected line arms the slot at the edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write control word of slot `cfg_idx` |
| cfg_idx | input | 4 | Slot addressed by configuration writes |
| cfg_word | input | 16 | Packed control word |
| rtg_we | input | 1 | Write re-arm field of slot `cfg_idx` |
| rtg_sel | input | 2 | Re-arm field value |
| force_we | input | 1 | Apply software force mask |
| force_mask | input | 16 | Slots to arm by software |
| ovf_clr_we | input | 1 | Apply overflow clear mask |
| ovf_clr_mask | input | 16 | Overflow flags to clear |
| tmr_trig | input | 4 | Timer trigger lines (codes 1 to 4) |
| ext_trig | input | 8 | External trigger lines (codes 5 to 12) |
| int1_slot | input | 4 | Slot whose completion pulses `int1` |
| int2_slot | input | 4 | Slot whose completion pulses `int2` |
| rd_idx | input | 4 | Result register read index |
| rd_data | output | 12 | Result register addressed by `rd_idx` |
| pending | output | 16 | Per-slot pending flags |
| overflow | output | 16 | Per-slot sticky overflow flags |
| busy | output | 1 | A conversion is in progress |
| res_we | output | 1 | One-cycle result write strobe |
| res_slot | output | 4 | Slot of the result being written |
| res_data | output | 12 | Result being written |
| int1 | output | 1 | Interrupt line 1 pulse |
| int2 | output | 1 | Interrupt line 2 pulse |

## Verification
A trigger edge, force or interrupt pulse shows up in `pending` one edge after it is sampled. When the block is idle, the grant follows one edge later and `busy` rises. From there the result strobe is due max(field, 6) + 1 + 4 cycles later, in the cycle right after `busy` falls. The scoreboard monitor counts the `busy` cycles before each `res_we` and compares that count with the window the driver queued for the slot. The driver samples flags at the falling edge after the edge that should set them. It pushes items in the round-robin order it works out from R8, and the monitor pops them in arrival order, so a wrong order or a wrong sequence number shows as a mismatch.

// File: rtl/soc_seq_pkg.sv
package soc_seq_pkg;
    localparam int WIN_W  = 6;
    localparam int CHAN_W = 4;
    localparam int TSEL_W = 5;
    localparam int N_TMR  = 4;
    localparam int N_EXT  = 8;
    localparam int N_TSEL = 1 << TSEL_W;

    // Field positions are fixed by the software-visible word layout.
    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic              spare;
        logic [CHAN_W-1:0] chan;
        logic [WIN_W-1:0]  win;
    } ctl_word_t;

    typedef enum logic [1:0] {
        RTG_NONE  = 2'd0,
        RTG_LINE1 = 2'd1,
        RTG_LINE2 = 2'd2,
        RTG_OFF   = 2'd3
    } rtg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_e;
endpackage

// File: rtl/soc_slot_bank.sv
module soc_slot_bank #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] hit,
    input  logic               take_valid,
    input  logic [IDX_W-1:0]   take_idx,
    input  logic               ovf_clr_we,
    input  logic [N_SLOTS-1:0] ovf_clr_mask,
    output logic [N_SLOTS-1:0] pending,
    output logic [N_SLOTS-1:0] overflow
);
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic pend_r;
        logic ovf_r;
        logic take;

        assign take = take_valid && (take_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r <= 1'b0;
                ovf_r  <= 1'b0;
            end else begin
                pend_r <= hit[g] | (pend_r & ~take);
                ovf_r  <= (hit[g] & pend_r & ~take)
                        | (ovf_r & ~(ovf_clr_we & ovf_clr_mask[g]));
            end
        end

        assign pending[g]  = pend_r;
        assign overflow[g] = ovf_r;
    end
endmodule

// File: rtl/soc_rr_arbiter.sv
module soc_rr_arbiter #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] req,
    input  logic [IDX_W-1:0]   last_idx,
    output logic               gnt_valid,
    output logic [IDX_W-1:0]   gnt_idx
);
    // Scan from the farthest offset down, so the nearest requester after last_idx is kept.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int off = N_SLOTS; off >= 1; off--) begin
            if (req[(int'(last_idx) + off) % N_SLOTS]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'((int'(last_idx) + off) % N_SLOTS);
            end
        end
    end
endmodule

// File: rtl/soc_conv_stub.sv
module soc_conv_stub #(
    parameter int CONV_LAT = 4,
    parameter int CHAN_W   = 4,
    parameter int RES_W    = 12,
    localparam int SEQ_W   = RES_W - CHAN_W,
    localparam int CNT_W   = $clog2(CONV_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    output logic              done,
    output logic [RES_W-1:0]  data
);
    logic              run_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CHAN_W-1:0] chan_q;
    logic [SEQ_W-1:0]  seq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            chan_q <= '0;
            seq_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            cnt_q  <= CNT_W'(CONV_LAT - 1);
            chan_q <= chan;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
                seq_q <= seq_q + 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = run_q && (cnt_q == '0);
    assign data = {chan_q, seq_q};
endmodule

// File: rtl/soc_sequencer.sv
module soc_sequencer
    import soc_seq_pkg::*;
#(
    parameter int N_SLOTS  = 16,
    parameter int RES_W    = 12,
    parameter int CONV_LAT = 4,
    parameter int MIN_WIN  = 6,
    localparam int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [15:0]        cfg_word,
    input  logic               rtg_we,
    input  logic [1:0]         rtg_sel,
    input  logic               force_we,
    input  logic [N_SLOTS-1:0] force_mask,
    input  logic               ovf_clr_we,
    input  logic [N_SLOTS-1:0] ovf_clr_mask,
    input  logic [N_TMR-1:0]   tmr_trig,
    input  logic [N_EXT-1:0]   ext_trig,
    input  logic [IDX_W-1:0]   int1_slot,
    input  logic [IDX_W-1:0]   int2_slot,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [RES_W-1:0]   rd_data,
    output logic [N_SLOTS-1:0] pending,
    output logic [N_SLOTS-1:0] overflow,
    output logic               busy,
    output logic               res_we,
    output logic [IDX_W-1:0]   res_slot,
    output logic [RES_W-1:0]   res_data,
    output logic               int1,
    output logic               int2
);
    localparam int PAD_W = N_TSEL - 1 - N_TMR - N_EXT;

    // Configuration storage
    ctl_word_t                       w_in;
    logic                            unused_spare;
    logic [N_SLOTS-1:0][TSEL_W-1:0]  cfg_tsel;
    logic [N_SLOTS-1:0][CHAN_W-1:0]  cfg_chan;
    logic [N_SLOTS-1:0][WIN_W-1:0]   cfg_win;
    logic [N_SLOTS-1:0][1:0]         cfg_rtg;

    assign w_in         = cfg_word;
    assign unused_spare = w_in.spare;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_tsel <= '0;
            cfg_chan <= '0;
            cfg_win  <= '0;
            cfg_rtg  <= '0;
        end else begin
            if (cfg_we) begin
                cfg_tsel[cfg_idx] <= w_in.tsel;
                cfg_chan[cfg_idx] <= w_in.chan;
                cfg_win[cfg_idx]  <= w_in.win;
            end
            if (rtg_we) cfg_rtg[cfg_idx] <= rtg_sel;
        end
    end

    // Trigger edge detection and per-slot arming
    logic [N_TMR-1:0]   tmr_q;
    logic [N_EXT-1:0]   ext_q;
    logic [N_TSEL-1:0]  evt;
    logic [N_SLOTS-1:0] hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            ext_q <= '0;
        end else begin
            tmr_q <= tmr_trig;
            ext_q <= ext_trig;
        end
    end

    assign evt = {{PAD_W{1'b0}}, ext_trig & ~ext_q, tmr_trig & ~tmr_q, 1'b0};

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_hit
        assign hit[g] = evt[cfg_tsel[g]]
                      | (force_we & force_mask[g])
                      | ((cfg_rtg[g] == RTG_LINE1) & int1)
                      | ((cfg_rtg[g] == RTG_LINE2) & int2);
    end

    // Controller state
    seq_state_e         state_q, state_d;
    logic [WIN_W-1:0]   cnt_q, cnt_d;
    logic [WIN_W-1:0]   win_q, win_d;
    logic [CHAN_W-1:0]  chan_q, chan_d;
    logic [IDX_W-1:0]   cur_q, cur_d;
    logic [IDX_W-1:0]   last_q, last_d;
    logic               take;
    logic               conv_start;
    logic               conv_done;
    logic [RES_W-1:0]   conv_data;
    logic               gnt_valid;
    logic [IDX_W-1:0]   gnt_idx;

    soc_slot_bank #(.N_SLOTS(N_SLOTS)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .take_valid   (take),
        .take_idx     (gnt_idx),
        .ovf_clr_we   (ovf_clr_we),
        .ovf_clr_mask (ovf_clr_mask),
        .pending      (pending),
        .overflow     (overflow)
    );

    soc_rr_arbiter #(.N_SLOTS(N_SLOTS)) u_arb (
        .req       (pending),
        .last_idx  (last_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    soc_conv_stub #(.CONV_LAT(CONV_LAT), .CHAN_W(CHAN_W), .RES_W(RES_W)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .chan  (chan_q),
        .done  (conv_done),
        .data  (conv_data)
    );

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        win_d      = win_q;
        chan_d     = chan_q;
        cur_d      = cur_q;
        last_d     = last_q;
        take       = 1'b0;
        conv_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (gnt_valid) begin
                    take    = 1'b1;
                    cur_d   = gnt_idx;
                    chan_d  = cfg_chan[gnt_idx];
                    win_d   = (cfg_win[gnt_idx] < WIN_W'(MIN_WIN)) ? WIN_W'(MIN_WIN)
                                                                   : cfg_win[gnt_idx];
                    cnt_d   = '0;
                    state_d = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == win_q) begin
                    conv_start = 1'b1;
                    state_d    = ST_CONVERT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    last_d  = cur_q;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            win_q   <= '0;
            chan_q  <= '0;
            cur_q   <= '0;
            last_q  <= IDX_W'(N_SLOTS - 1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            win_q   <= win_d;
            chan_q  <= chan_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
        end
    end

    // Outputs and result registers
    logic [N_SLOTS-1:0][RES_W-1:0] res_mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_we   <= 1'b0;
            res_slot <= '0;
            res_data <= '0;
            int1     <= 1'b0;
            int2     <= 1'b0;
            res_mem  <= '0;
        end else begin
            res_we <= 1'b0;
            int1   <= 1'b0;
            int2   <= 1'b0;
            if (state_q == ST_CONVERT && conv_done) begin
                res_we         <= 1'b1;
                res_slot       <= cur_q;
                res_data       <= conv_data;
                res_mem[cur_q] <= conv_data;
                int1           <= (cur_q == int1_slot);
                int2           <= (cur_q == int2_slot);
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign rd_data = res_mem[rd_idx];
endmodule

// File: rtl/soc_seq_checker.sv
module soc_seq_checker #(
    parameter int N_SLOTS  = 16,
    parameter int CONV_LAT = 4,
    parameter int MIN_WIN  = 6,
    localparam int IDX_W   = $clog2(N_SLOTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SLOTS-1:0] pending,
    input logic [N_SLOTS-1:0] overflow,
    input logic               ovf_clr_we,
    input logic               busy,
    input logic               res_we,
    input logic [IDX_W-1:0]   res_slot,
    input logic               int1,
    input logic               int2,
    input logic [IDX_W-1:0]   int1_slot,
    input logic [IDX_W-1:0]   int2_slot
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    p_ovf_only_on_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((overflow & ~$past(overflow) & ~$past(pending)) == '0));

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_clr_we |=> ((overflow & $past(overflow)) == $past(overflow)));

    p_single_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> !busy);

    p_grant_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(pending) != '0));

    p_window_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt >= 16'(MIN_WIN + 1 + CONV_LAT)));

    p_result_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_we);

    p_int1_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int1 |-> (res_we && res_slot == int1_slot));

    p_int2_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int2 |-> (res_we && res_slot == int2_slot));
endmodule

bind soc_sequencer soc_seq_checker #(
    .N_SLOTS  (N_SLOTS),
    .CONV_LAT (CONV_LAT),
    .MIN_WIN  (MIN_WIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pending),
    .overflow   (overflow),
    .ovf_clr_we (ovf_clr_we),
    .busy       (busy),
    .res_we     (res_we),
    .res_slot   (res_slot),
    .int1       (int1),
    .int2       (int2),
    .int1_slot  (int1_slot),
    .int2_slot  (int2_slot)
);

// File: tb/soc_sequencer_tb_top.sv
module soc_sequencer_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_word = '0;
    logic        rtg_we = 1'b0;
    logic [1:0]  rtg_sel = '0;
    logic        force_we = 1'b0;
    logic [15:0] force_mask = '0;
    logic        ovf_clr_we = 1'b0;
    logic [15:0] ovf_clr_mask = '0;
    logic [3:0]  tmr_trig = '0;
    logic [7:0]  ext_trig = '0;
    logic [3:0]  int1_slot = 4'd15;
    logic [3:0]  int2_slot = 4'd15;
    logic [3:0]  rd_idx = '0;
    logic [11:0] rd_data;
    logic [15:0] pending;
    logic [15:0] overflow;
    logic        busy;
    logic        res_we;
    logic [3:0]  res_slot;
    logic [11:0] res_data;
    logic        int1;
    logic        int2;

    always #10 clk = ~clk;

    soc_sequencer #(.CONV_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
        .rtg_we(rtg_we), .rtg_sel(rtg_sel), .force_we(force_we), .force_mask(force_mask),
        .ovf_clr_we(ovf_clr_we), .ovf_clr_mask(ovf_clr_mask), .tmr_trig(tmr_trig),
        .ext_trig(ext_trig), .int1_slot(int1_slot), .int2_slot(int2_slot), .rd_idx(rd_idx),
        .rd_data(rd_data), .pending(pending), .overflow(overflow), .busy(busy),
        .res_we(res_we), .res_slot(res_slot), .res_data(res_data), .int1(int1), .int2(int2)
    );

    typedef struct {
        int slot;
        int data;
        int cyc;
        int i1;
        int i2;
    } item_t;

    item_t exp_q[$];
    int    exp_mem[16];
    int    exp_seq = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    busy_cnt = 0;
    bit    finished = 1'b0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Driver side: expected item from R1, R7, R9
    task automatic push(int slot, int ch, int win, int i1, int i2);
        item_t it;
        int w;
        w = (win < 6) ? 6 : win;
        it.slot = slot;
        it.data = (ch << 8) | (exp_seq & 255);
        it.cyc  = w + 1 + LAT;
        it.i1   = i1;
        it.i2   = i2;
        exp_seq++;
        exp_mem[slot] = it.data;
        exp_q.push_back(it);
    endtask

    task automatic write_cfg(int idx, logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_rtg(int idx, logic [1:0] v);
        @(negedge clk);
        rtg_we = 1'b1; cfg_idx = 4'(idx); rtg_sel = v;
        @(negedge clk);
        rtg_we = 1'b0;
    endtask

    task automatic pulse_ext(int b);
        @(negedge clk);
        ext_trig[b] = 1'b1;
        @(negedge clk);
        ext_trig[b] = 1'b0;
    endtask

    task automatic force_slots(logic [15:0] m);
        @(negedge clk);
        force_we = 1'b1; force_mask = m;
        @(negedge clk);
        force_we = 1'b0; force_mask = '0;
    endtask

    task automatic clear_ovf(logic [15:0] m);
        @(negedge clk);
        ovf_clr_we = 1'b1; ovf_clr_mask = m;
        @(negedge clk);
        ovf_clr_we = 1'b0; ovf_clr_mask = '0;
    endtask

    task automatic wait_drain();
        int guard;
        guard = 0;
        while ((exp_q.size() != 0 || busy || res_we || pending != 0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) check("R6", "drain timeout", 1, 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop and compare each result as it is written
    always @(negedge clk) begin
        item_t it;
        if (!rst_n) begin
            busy_cnt = 0;
        end else begin
            if (busy) busy_cnt++;
            if (res_we) begin
                if (exp_q.size() == 0) begin
                    check("R6", "unexpected result slot", int'(res_slot), -1);
                end else begin
                    it = exp_q.pop_front();
                    check("R8", "service order slot", int'(res_slot), it.slot);
                    check("R1", "result data", int'(res_data), it.data);
                    check("R7", "busy cycles", busy_cnt, it.cyc);
                    check("R9", "int1", int'(int1), it.i1);
                    check("R9", "int2", int'(int2), it.i2);
                end
                busy_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R6", "reset pending", int'(pending), 0);
        check("R4", "reset overflow", int'(overflow), 0);
        check("R6", "reset busy", int'(busy), 0);
        check("R9", "reset int1", int'(int1), 0);
        check("R1", "reset result reg", int'(rd_data), 0);

        // Single conversion: word 2846h = window 6, channel 1, code 5 (ext bit 0)
        write_cfg(0, 16'h2846);
        push(0, 1, 6, 0, 0);
        pulse_ext(0);
        check("R2", "pending after ext edge", int'(pending), 16'h0001);
        wait_drain();
        rd_idx = 4'd0; #1;
        check("R1", "result reg 0", int'(rd_data), exp_mem[0]);

        // Oversampling on one trigger, round-robin from slot 1
        write_cfg(1, 16'h2846);
        write_cfg(2, 16'h2846);
        write_cfg(3, 16'h2C46); // bit 10 set: must be ignored
        push(1, 1, 6, 0, 0); push(2, 1, 6, 0, 0); push(3, 1, 6, 0, 0); push(0, 1, 6, 0, 0);
        pulse_ext(0);
        check("R2", "four slots pending", int'(pending), 16'h000F);
        wait_drain();

        // Overflow: second edge two cycles later hits slots 0,2,3; slot 1 re-arms
        push(1, 1, 6, 0, 0); push(2, 1, 6, 0, 0); push(3, 1, 6, 0, 0);
        push(0, 1, 6, 0, 0); push(1, 1, 6, 0, 0);
        pulse_ext(0);
        pulse_ext(0);
        check("R3", "overflow on pending slots", int'(overflow), 16'h000D);
        check("R6", "granted slot re-armed", int'(pending), 16'h000F);
        wait_drain();
        check("R4", "overflow sticky", int'(overflow), 16'h000D);
        clear_ovf(16'h0005);
        check("R4", "partial clear", int'(overflow), 16'h0008);
        clear_ovf(16'hFFFF);
        check("R4", "full clear", int'(overflow), 0);

        // Timer codes, window clamp, held level gives one event
        write_cfg(5, 16'h11D4); // code 2, channel 7, window 20
        write_cfg(6, 16'h0A42); // code 1, channel 9, window 2 -> clamped
        push(5, 7, 20, 0, 0); push(6, 9, 2, 0, 0);
        @(negedge clk);
        tmr_trig = 4'b0011;
        repeat (3) @(negedge clk);
        tmr_trig = 4'b0000;
        wait_drain();
        check("R2", "held level no extra event", int'(overflow), 0);

        // Unused code 12 line: nothing arms
        pulse_ext(7);
        check("R2", "unselected line ignored", int'(pending), 0);
        @(negedge clk);
        check("R2", "no conversion from unselected line", int'(busy), 0);

        // Software force, and force overflow
        write_cfg(8, 16'h0086);
        write_cfg(9, 16'h00C6);
        push(8, 2, 6, 0, 0); push(9, 3, 6, 0, 0);
        force_slots(16'h0300);
        check("R5", "force arms", int'(pending), 16'h0300);
        force_slots(16'h0200);
        check("R5", "force overflow", int'(overflow), 16'h0200);
        check("R5", "force not queued", int'(pending), 16'h0200);
        wait_drain();
        clear_ovf(16'hFFFF);

        // Interrupt chaining: 10 -> int1 -> 11 -> int2 -> 12; slot 13 uses code 3 (none)
        write_cfg(10, 16'h0106);
        write_cfg(11, 16'h0146);
        write_cfg(12, 16'h0186);
        write_cfg(13, 16'h0106);
        write_rtg(11, 2'd1);
        write_rtg(12, 2'd2);
        write_rtg(13, 2'd3);
        int1_slot = 4'd10;
        int2_slot = 4'd11;
        push(10, 4, 6, 1, 0); push(11, 5, 6, 0, 1); push(12, 6, 6, 0, 0);
        force_slots(16'h0400);
        wait_drain();
        check("R10", "re-arm code 3 arms nothing", int'(pending), 0);
        check("R10", "no overflow from chain", int'(overflow), 0);

        // All result registers
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx = 4'(i);
            #1;
            check("R1", $sformatf("result reg %0d", i), int'(rd_data), exp_mem[i]);
        end

        check("R6", "queue empty at end", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule